// File: doc/BRIEF.md
# Cycle-Steal DMA Request Sequencer

This block is the front end of one DMA channel that serves a peripheral which signals each wanted transfer with a pulse. Every falling edge on the active-low request input becomes one pending operand move. The sequencer asks the bus arbiter for the bus. Once it holds the grant, it runs a read bus cycle at the source address and then a write bus cycle at the destination address, which carries the data just read. On the cycle that touches the peripheral it drives an active-low acknowledge strobe, shaped like the address strobe.

Only one request can wait at a time; edges that arrive while one is waiting are dropped. An operand counter is loaded together with the two start addresses. It stops the channel after the programmed number of moves and raises a done flag, which stays high until it is cleared. A mode input chooses whether the request passes through one or two sampling registers. Another mode input chooses whether the peripheral is the source or the destination.

Top module: `cs_dma_seq`

## Requirements
- R1: When `sync_bypass_i`=1, the first rising clock edge that samples `req_ni` low is followed one edge later by `bus_req_o`=1. When `sync_bypass_i`=0, `bus_req_o`=1 comes two edges after that sample. This applies while the channel is armed and idle.
- R2: A falling edge on `req_ni` while a request is already waiting, and not yet in service, is dropped. Two edges before the grant give exactly one operand.
- R3: A falling edge after service of the waiting request has begun creates a new waiting request, which is then served as one more operand.
- R4: Each operand is a read cycle (`rw_o`=1) at the source address, then a write cycle (`rw_o`=0) at the destination address. `wdata_o` carries the `rdata_i` value taken in the read cycle.
- R5: A bus cycle starts only while `bus_grant_i`=1. If the grant is withdrawn after the read, no write cycle runs until the grant returns, and then the write completes.
- R6: `as_no` stays low from the first S2 cycle until `ta_ni` is sampled low, then for one S4 cycle more, and then goes high. Its low time is (wait cycles + 2) clocks.
- R7: `ack_no` equals `as_no` on the peripheral's cycle and is 1 at all other times. The peripheral's cycle is the read when `periph_rd_i`=1 and the write when `periph_rd_i`=0.
- R8: After each completed write, the source and destination addresses each advance by OP_BYTES (default 4), unless the hold input for that side is 1.
- R9: `cfg_load_i` loads the addresses and an operand count N, and clears done. After N operands `done_o`=1 and later request edges cause no cycle. `done_clr_i` clears `done_o`.
- R10: Reset clears any waiting request and drives `bus_req_o`=0, `as_no`=1, `ack_no`=1 and `done_o`=0. It also leaves the channel unarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | 1 | Peripheral request, falling edge asks for one operand |
| ack_no | output | 1 | Peripheral acknowledge strobe, active low |
| periph_rd_i | input | 1 | 1: peripheral is source (read); 0: peripheral is destination (written) |
| sync_bypass_i | input | 1 | 1: one sampling register on the request; 0: two |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| as_no | output | 1 | Address strobe, active low |
| rw_o | output | 1 | 1 read cycle, 0 write cycle |
| addr_o | output | AW | Bus address |
| rdata_i | input | DW | Read data |
| wdata_o | output | DW | Write data |
| ta_ni | input | 1 | Transfer acknowledge, active low |
| cfg_load_i | input | 1 | Load addresses and count, clear done |
| src_init_i | input | AW | Source start address |
| dst_init_i | input | AW | Destination start address |
| cnt_init_i | input | CW | Number of operands to move |
| src_hold_i | input | 1 | Keep source address fixed |
| dst_hold_i | input | 1 | Keep destination address fixed |
| done_o | output | 1 | Count exhausted |
| done_clr_i | input | 1 | Clear done flag |

## Verification
The stimulus changes on falling clock edges and every output is read on falling edges, so each rising edge has a known effect. The request latency is checked by counting falling edges after `req_ni` drops: `bus_req_o` must still be low at the first and high at the second (bypass) or third (synchronized). The bus model raises transfer acknowledge in the falling edge before the rising edge that should end the wait. It logs a read or write at the next falling edge, when the sequencer is in S4, and it times the strobe's low run there. Counts of completed operands, their addresses and their data are compared only after the bus request has stayed low for three cycles.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_R0, ST_R2, ST_R4, ST_WHOLD, ST_W0, ST_W2, ST_W4
  } seq_st_t;

  // next address after one operand; wide arithmetic, caller truncates
  function automatic logic [63:0] addr_step(logic [63:0] a, logic hold, int unsigned step);
    return hold ? a : a + 64'(step);
  endfunction

  // the peripheral is touched when the cycle direction matches its side
  function automatic logic periph_cycle(logic periph_rd, logic is_read);
    return periph_rd == is_read;
  endfunction

endpackage

// File: rtl/csd_req_edge.sv
module csd_req_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic sync_bypass_i,
  output logic fall_o
);
  logic smp1_q, smp2_q, prev_q;
  logic sel;

  assign sel = sync_bypass_i ? smp1_q : smp2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp1_q <= 1'b1;
      smp2_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      smp1_q <= req_ni;
      smp2_q <= smp1_q;
      prev_q <= sel;
    end
  end

  assign fall_o = prev_q & ~sel;

  // R1
  single_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/csd_cycle_fsm.sv
module csd_cycle_fsm
  import csd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pending_i,
  input  logic grant_i,
  input  logic ta_ni,
  input  logic periph_rd_i,
  output logic start_o,
  output logic rd_take_o,
  output logic op_done_o,
  output logic busy_o,
  output logic as_no,
  output logic rw_o,
  output logic ack_no
);
  seq_st_t st_q, st_d;
  logic in_s2, in_s4;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (pending_i && grant_i) st_d = ST_R0;
      ST_R0:    st_d = ST_R2;
      ST_R2:    if (!ta_ni) st_d = ST_R4;
      ST_R4:    st_d = grant_i ? ST_W0 : ST_WHOLD;
      ST_WHOLD: if (grant_i) st_d = ST_W0;
      ST_W0:    st_d = ST_W2;
      ST_W2:    if (!ta_ni) st_d = ST_W4;
      ST_W4:    st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign in_s2     = (st_q == ST_R2) || (st_q == ST_W2);
  assign in_s4     = (st_q == ST_R4) || (st_q == ST_W4);
  assign start_o   = (st_q == ST_IDLE) && pending_i && grant_i;
  assign rd_take_o = (st_q == ST_R2) && !ta_ni;
  assign op_done_o = (st_q == ST_W4);
  assign busy_o    = (st_q != ST_IDLE);
  assign as_no     = !(in_s2 || in_s4);
  assign rw_o      = !((st_q == ST_W0) || (st_q == ST_W2) || (st_q == ST_W4));
  assign ack_no    = as_no | !periph_cycle(periph_rd_i, rw_o);

  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_s2 && ta_ni) |=> !as_no);
  // R6
  s4_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_s4 |=> as_no);
  // R5
  write_waits_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WHOLD && !grant_i) |=> (st_q == ST_WHOLD));
  // R7
  ack_inside_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> !as_no);

endmodule

// File: rtl/csd_addr_cnt.sv
module csd_addr_cnt
  import csd_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned CW   = 16,
  parameter int unsigned STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] src_init_i,
  input  logic [AW-1:0] dst_init_i,
  input  logic [CW-1:0] cnt_init_i,
  input  logic          src_hold_i,
  input  logic          dst_hold_i,
  input  logic          op_done_i,
  input  logic          done_clr_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          armed_o,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;
  logic          last_op;

  assign last_op = op_done_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (cfg_load_i) begin
      src_o  <= src_init_i;
      dst_o  <= dst_init_i;
      cnt_q  <= cnt_init_i;
      done_o <= 1'b0;
    end else begin
      if (op_done_i) begin
        src_o <= AW'(addr_step(64'(src_o), src_hold_i, STEP));
        dst_o <= AW'(addr_step(64'(dst_o), dst_hold_i, STEP));
        if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
      end
      if (last_op)         done_o <= 1'b1;
      else if (done_clr_i) done_o <= 1'b0;
    end
  end

  assign armed_o = (cnt_q != '0);

  // R9
  done_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !armed_o);
  // R8
  src_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && !src_hold_i && !cfg_load_i) |=> (src_o == $past(src_o) + AW'(STEP)));
  // R8
  dst_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && dst_hold_i && !cfg_load_i) |=> $stable(dst_o));

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned CW       = 16,
  parameter int unsigned OP_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_ni,
  output logic          ack_no,
  input  logic          periph_rd_i,
  input  logic          sync_bypass_i,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  output logic          as_no,
  output logic          rw_o,
  output logic [AW-1:0] addr_o,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] wdata_o,
  input  logic          ta_ni,
  input  logic          cfg_load_i,
  input  logic [AW-1:0] src_init_i,
  input  logic [AW-1:0] dst_init_i,
  input  logic [CW-1:0] cnt_init_i,
  input  logic          src_hold_i,
  input  logic          dst_hold_i,
  output logic          done_o,
  input  logic          done_clr_i
);
  logic          req_fall, pending_q, armed;
  logic          svc_start, rd_take, op_done, busy;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] data_q;

  csd_req_edge u_edge (
    .clk_i, .rst_ni, .req_ni, .sync_bypass_i, .fall_o(req_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pending_q <= 1'b0;
    else if (svc_start)          pending_q <= 1'b0;
    else if (req_fall && armed)  pending_q <= 1'b1;
  end

  csd_cycle_fsm u_fsm (
    .clk_i, .rst_ni,
    .pending_i(pending_q), .grant_i(bus_grant_i), .ta_ni,
    .periph_rd_i,
    .start_o(svc_start), .rd_take_o(rd_take), .op_done_o(op_done),
    .busy_o(busy), .as_no, .rw_o, .ack_no
  );

  csd_addr_cnt #(.AW(AW), .CW(CW), .STEP(OP_BYTES)) u_acnt (
    .clk_i, .rst_ni, .cfg_load_i, .src_init_i, .dst_init_i, .cnt_init_i,
    .src_hold_i, .dst_hold_i, .op_done_i(op_done), .done_clr_i,
    .src_o(src_addr), .dst_o(dst_addr), .armed_o(armed), .done_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (rd_take) data_q <= rdata_i;
  end

  assign bus_req_o = pending_q | busy;
  assign addr_o    = rw_o ? src_addr : dst_addr;
  assign wdata_o   = data_q;

  // R2
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !svc_start) |=> pending_q);
  // R3
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_start |=> !pending_q || $past(req_fall));
  // R5
  start_granted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_no) |-> $past(bus_grant_i, 2));

endmodule

// File: tb/test_cs_dma_seq.sv
module test_cs_dma_seq;
  localparam int CLK_T = 10;
  localparam logic [31:0] RMASK = 32'h5A00_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, periph_rd = 1'b1, sync_bypass = 1'b1, bus_grant = 1'b0;
  logic ta_n = 1'b1, cfg_load = 1'b0, src_hold = 1'b0, dst_hold = 1'b0, done_clr = 1'b0;
  logic [31:0] src_init = '0, dst_init = '0;
  logic [15:0] cnt_init = '0;
  logic ack_n, bus_req, as_n, rw, done;
  logic [31:0] addr, rdata, wdata;

  int n_chk = 0, n_fail = 0, waits = 0;
  int rd_cnt = 0, wr_cnt = 0, ack_bad = 0, ack_low = 0, as_run = 0, as_len = 0;
  logic [31:0] wr_addr [32];
  logic [31:0] wr_data [32];
  logic [31:0] rd_addr [32];
  bit finished = 0;

  always #(CLK_T/2) clk = ~clk;
  assign rdata = addr ^ RMASK;

  cs_dma_seq i_cs_dma_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .ack_no(ack_n),
    .periph_rd_i(periph_rd), .sync_bypass_i(sync_bypass),
    .bus_req_o(bus_req), .bus_grant_i(bus_grant), .as_no(as_n), .rw_o(rw),
    .addr_o(addr), .rdata_i(rdata), .wdata_o(wdata), .ta_ni(ta_n),
    .cfg_load_i(cfg_load), .src_init_i(src_init), .dst_init_i(dst_init),
    .cnt_init_i(cnt_init), .src_hold_i(src_hold), .dst_hold_i(dst_hold),
    .done_o(done), .done_clr_i(done_clr)
  );

  // bus slave and monitor: log first, then drive ta_n for the next edge
  always @(negedge clk) begin
    if (rst_n && !as_n && !ta_n) begin
      if (rw) begin rd_addr[rd_cnt % 32] = addr; rd_cnt++; end
      else begin wr_addr[wr_cnt % 32] = addr; wr_data[wr_cnt % 32] = wdata; wr_cnt++; end
    end
    if (ack_n !== (as_n | (rw != periph_rd))) ack_bad++;
    if (!ack_n) ack_low++;
    if (!as_n) as_run++;
    else begin if (as_run != 0) as_len = as_run; as_run = 0; end
    if (as_n) ta_n = 1'b1;
    else ta_n = (as_run == waits + 1) ? 1'b0 : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_quiet();
    int q = 0;
    for (int i = 0; i < 400 && q < 3; i++) begin
      @(negedge clk);
      q = bus_req ? 0 : q + 1;
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); req_n = 1'b0;
    cyc(2); req_n = 1'b1;
    cyc(2);
  endtask

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
    @(negedge clk);
    src_init = s; dst_init = d; cnt_init = c; cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic t_reset();
    chk(bus_req == 0, "R10 bus_req", bus_req, 0);
    chk(as_n == 1 && ack_n == 1, "R10 strobes", {as_n, ack_n}, 3);
    chk(done == 0, "R10 done", done, 0);
  endtask

  task automatic t_latency(input logic byp);
    int late = byp ? 2 : 3;
    bus_grant = 1'b0; sync_bypass = byp;
    load(32'h40, 32'h80, 16'd10);
    @(negedge clk); req_n = 1'b0;
    for (int k = 1; k <= late; k++) begin
      @(negedge clk);
      chk(bus_req == (k == late), byp ? "R1 bypass latency" : "R1 sync latency",
          bus_req, int'(k == late));
    end
    req_n = 1'b1; bus_grant = 1'b1;
    wait_quiet();
    sync_bypass = 1'b1;
  endtask

  task automatic t_basic(input logic prd);
    int r0 = rd_cnt, w0 = wr_cnt, al = ack_low;
    periph_rd = prd; bus_grant = 1'b1; ack_bad = 0;
    load(32'h100, 32'h200, 16'd8);
    pulse_req(); wait_quiet();
    pulse_req(); wait_quiet();
    chk(wr_cnt - w0 == 2 && rd_cnt - r0 == 2, "R4 operand count", wr_cnt - w0, 2);
    chk(rd_addr[r0 % 32] == 32'h100 && rd_addr[(r0+1) % 32] == 32'h104,
        "R8 source advance", int'(rd_addr[(r0+1) % 32]), 32'h104);
    chk(wr_addr[w0 % 32] == 32'h200 && wr_addr[(w0+1) % 32] == 32'h204,
        "R8 destination advance", int'(wr_addr[(w0+1) % 32]), 32'h204);
    chk(wr_data[(w0+1) % 32] == (32'h104 ^ RMASK), "R4 write data",
        int'(wr_data[(w0+1) % 32]), int'(32'h104 ^ RMASK));
    chk(ack_bad == 0, "R7 ack follows strobe", ack_bad, 0);
    chk(ack_low - al == 4, "R7 ack low cycles", ack_low - al, 4);
  endtask

  task automatic t_ignore();
    int w0;
    load(32'h300, 32'h400, 16'd8);
    w0 = wr_cnt; bus_grant = 1'b0;
    pulse_req(); pulse_req(); pulse_req();
    bus_grant = 1'b1; wait_quiet();
    chk(wr_cnt - w0 == 1, "R2 edges while pending", wr_cnt - w0, 1);
  endtask

  task automatic t_during();
    int w0 = wr_cnt;
    bus_grant = 1'b1;
    @(negedge clk); req_n = 1'b0;
    for (int i = 0; i < 50 && as_n; i++) @(negedge clk);
    req_n = 1'b1; cyc(2);
    req_n = 1'b0; cyc(2); req_n = 1'b1;
    wait_quiet();
    chk(wr_cnt - w0 == 2, "R3 edge during service", wr_cnt - w0, 2);
  endtask

  task automatic t_wait(input int w);
    waits = w; bus_grant = 1'b1;
    pulse_req(); wait_quiet();
    chk(as_len == w + 2, "R6 strobe length", as_len, w + 2);
    waits = 0;
  endtask

  task automatic t_grant();
    int w0 = wr_cnt;
    bool_loop: begin end
    bus_grant = 1'b1;
    @(negedge clk); req_n = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #1;
      if (!as_n && rw && !ta_n) break;
    end
    bus_grant = 1'b0; req_n = 1'b1;
    cyc(6);
    chk(wr_cnt == w0 && as_n == 1, "R5 write held without grant", wr_cnt - w0, 0);
    chk(bus_req == 1, "R5 request kept", bus_req, 1);
    bus_grant = 1'b1; wait_quiet();
    chk(wr_cnt - w0 == 1, "R5 write after regrant", wr_cnt - w0, 1);
  endtask

  task automatic t_count();
    int w0;
    bus_grant = 1'b1;
    load(32'h500, 32'h600, 16'd2);
    w0 = wr_cnt;
    pulse_req(); wait_quiet();
    chk(done == 0, "R9 not done early", done, 0);
    pulse_req(); wait_quiet();
    chk(done == 1, "R9 done at zero", done, 1);
    pulse_req(); wait_quiet();
    chk(wr_cnt - w0 == 2, "R9 no move after done", wr_cnt - w0, 2);
    @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    chk(done == 0, "R9 done cleared", done, 0);
  endtask

  task automatic t_hold();
    int r0, w0;
    bus_grant = 1'b1; src_hold = 1'b1;
    load(32'h700, 32'h800, 16'd4);
    r0 = rd_cnt; w0 = wr_cnt;
    pulse_req(); wait_quiet(); pulse_req(); wait_quiet();
    chk(rd_addr[(r0+1) % 32] == 32'h700, "R8 source held",
        int'(rd_addr[(r0+1) % 32]), 32'h700);
    chk(wr_addr[(w0+1) % 32] == 32'h804, "R8 destination steps",
        int'(wr_addr[(w0+1) % 32]), 32'h804);
    src_hold = 1'b0;
  endtask

  task automatic t_reset_pending();
    int r0;
    bus_grant = 1'b0;
    load(32'h900, 32'hA00, 16'd4);
    pulse_req();
    chk(bus_req == 1, "R10 pending before reset", bus_req, 1);
    @(negedge clk); rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    chk(bus_req == 0 && done == 0, "R10 reset clears", bus_req, 0);
    r0 = rd_cnt; bus_grant = 1'b1; cyc(10);
    chk(rd_cnt == r0, "R10 no cycle after reset", rd_cnt - r0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_T * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3); t_reset();
    @(negedge clk); rst_n = 1'b1;
    cyc(2); t_reset();
    t_latency(1'b1);
    t_latency(1'b0);
    t_basic(1'b1);
    t_basic(1'b0);
    periph_rd = 1'b1;
    t_ignore();
    t_during();
    t_wait(0);
    t_wait(3);
    t_grant();
    t_count();
    t_hold();
    t_reset_pending();
    finish_run();
  end
endmodule